// File: doc/BRIEF.md
# Request-Port to Wishbone Classic Master Bridge

This block sits between a processing core's simple memory-request port and a Wishbone classic bus. The core presents an address, write data, an access width given as a number of bits (8, 16 or 32), and one strobe for writes or one for reads. The bridge latches the request and opens a single standard Wishbone cycle with cyc and stb raised together. It drives the aligned word address, the byte-lane selects, the write enable and the lane-replicated write data for the whole cycle, and waits for the slave's ack.

When ack arrives the bridge closes the cycle on the next clock edge. On that same edge it raises a one-clock ready pulse towards the core. For a read, the pulse carries the selected lanes shifted down to the low bits and zero-extended. The bridge takes a new request only while it is idle. A strobe that arrives while a bus cycle is open is dropped and not queued.

Top module: `mem_wb_bridge`

## Requirements
- R1: During reset and on the first edge after it, wb_cyc_o, wb_stb_o, wb_we_o and rsp_rdy are all low.
- R2: In the idle state, a cycle with req_wr or req_rd high makes wb_cyc_o and wb_stb_o high after the next rising edge. wb_we_o is 1 when req_wr was high, so a write wins if both strobes are high, and 0 for a read-only request.
- R3: wb_stb_o equals wb_cyc_o on every cycle.
- R4: While wb_cyc_o is high and wb_ack_i is low, wb_adr_o, wb_dat_o, wb_sel_o and wb_we_o hold their values. wb_adr_o is req_addr with its two low bits cleared.
- R5: An edge that samples wb_ack_i high while wb_cyc_o is high drops wb_cyc_o and wb_stb_o after that edge. Each accepted request produces exactly one bus cycle.
- R6: rsp_rdy goes high for exactly one clock, after the edge that sampled ack. This happens for writes and for reads.
- R7: wb_sel_o bit i enables data bits 8i+7..8i. Size 8 sets bit req_addr[1:0]. Size 16 sets bits {1,0} when req_addr[1]=0 and bits {3,2} when req_addr[1]=1. Size 32 sets all four bits. Any other size value is handled as 32, and wb_sel_o is never zero during a cycle.
- R8: For size 8, wb_dat_o repeats req_wdata[7:0] in all four lanes. For size 16 it repeats req_wdata[15:0] in both halves. For 32 and any unsupported size it is req_wdata unchanged.
- R9: With rsp_rdy after a read, rsp_rdata holds the selected lanes of wb_dat_i shifted down to bit 0, with all upper bits zero.
- R10: req_wr and req_rd are ignored while a bus cycle is open. The cycle's address and data do not change, and no further cycle follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data, low-aligned |
| req_size | input | $clog2(DATA_W)+1 | Access width in bits |
| req_wr | input | 1 | Write request strobe |
| req_rd | input | 1 | Read request strobe |
| rsp_rdy | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read data, low-aligned, valid with rsp_rdy |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | ADDR_W | Word-aligned Wishbone address |
| wb_dat_o | output | DATA_W | Wishbone write data |
| wb_sel_o | output | DATA_W/8 | Wishbone byte selects |
| wb_dat_i | input | DATA_W | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |

## Verification
The bound checker watches the handshake on every cycle. It checks that stb tracks cyc, that the address, data, selects and write enable stay frozen until ack, that the cycle closes right after ack, that the ready pulse lasts one clock and only follows an ack, and that selects are never empty. The lane mapping needs the bench's scenarios: which lanes a given size and address pick, how write data is replicated, and how read data is shifted down. Write priority on a double strobe, dropping strobes while busy, and the absence of a trailing cycle also come only from the bench.

// File: rtl/mem_wb_pkg.sv
package mem_wb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } bus_state_e;

endpackage

// File: rtl/mem_wb_lane_map.sv
module mem_wb_lane_map #(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int CNT_W  = OFF_W + 1,
    localparam int SIZE_W = $clog2(DATA_W) + 1
) (
    input  logic [SIZE_W-1:0] size_bits,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  sel,
    output logic [DATA_W-1:0] wdata_rep,
    output logic [OFF_W-1:0]  lane_off,
    output logic [CNT_W-1:0]  lane_cnt
);

    logic [SIZE_W-1:0] nbytes_raw;
    logic              size_ok;
    logic [OFF_W-1:0]  lane_mask;
    logic [LANES-1:0]  sel_base;

    // width decode: power-of-two byte counts up to the bus width are legal
    always_comb begin
        nbytes_raw = size_bits >> 3;
        size_ok    = (size_bits[2:0] == 3'b000)
                  && (nbytes_raw != '0)
                  && ((nbytes_raw & (nbytes_raw - 1'b1)) == '0)
                  && (nbytes_raw <= SIZE_W'(LANES));
        lane_cnt   = size_ok ? nbytes_raw[CNT_W-1:0] : CNT_W'(LANES);
        lane_mask  = OFF_W'(lane_cnt - 1'b1);
        lane_off   = addr_lo & ~lane_mask;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFF_W-1:0] src_lane;
        always_comb begin
            sel_base[i] = (CNT_W'(i) < lane_cnt);
            src_lane    = OFF_W'(i) & lane_mask;
            wdata_rep[i*8 +: 8] = wdata[{src_lane, 3'b000} +: 8];
        end
    end

    assign sel = sel_base << lane_off;

endmodule

// File: rtl/mem_wb_rd_align.sv
module mem_wb_rd_align #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic [DATA_W-1:0] bus_data,
    input  logic [OFF_W-1:0]  lane_off,
    input  logic [CNT_W-1:0]  lane_cnt,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] shifted;

    assign shifted = bus_data >> {lane_off, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_keep
        assign rdata[i*8 +: 8] = (CNT_W'(i) < lane_cnt) ? shifted[i*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/mem_wb_bridge.sv
module mem_wb_bridge
    import mem_wb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int CNT_W  = OFF_W + 1,
    localparam int SIZE_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_wr,
    input  logic              req_rd,
    output logic              rsp_rdy,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic [LANES-1:0]  wb_sel_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i
);

    typedef struct packed {
        bus_state_e        st;
        logic              cyc;
        logic              we;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] dat;
        logic [LANES-1:0]  sel;
        logic [OFF_W-1:0]  off;
        logic [CNT_W-1:0]  cnt;
        logic              rdy;
        logic [DATA_W-1:0] rdata;
    } bridge_regs_t;

    bridge_regs_t r_d, r_q;

    logic [LANES-1:0]  map_sel;
    logic [DATA_W-1:0] map_wdata;
    logic [OFF_W-1:0]  map_off;
    logic [CNT_W-1:0]  map_cnt;
    logic [DATA_W-1:0] rd_aligned;

    mem_wb_lane_map #(.DATA_W(DATA_W)) u_lane_map (
        .size_bits (req_size),
        .addr_lo   (req_addr[OFF_W-1:0]),
        .wdata     (req_wdata),
        .sel       (map_sel),
        .wdata_rep (map_wdata),
        .lane_off  (map_off),
        .lane_cnt  (map_cnt)
    );

    mem_wb_rd_align #(.DATA_W(DATA_W)) u_rd_align (
        .bus_data (wb_dat_i),
        .lane_off (r_q.off),
        .lane_cnt (r_q.cnt),
        .rdata    (rd_aligned)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rdy = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_wr || req_rd) begin
                    r_d.st  = ST_BUS;
                    r_d.cyc = 1'b1;
                    r_d.we  = req_wr;
                    r_d.adr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                    r_d.dat = map_wdata;
                    r_d.sel = map_sel;
                    r_d.off = map_off;
                    r_d.cnt = map_cnt;
                end
            end
            ST_BUS: begin
                if (wb_ack_i) begin
                    r_d.st    = ST_IDLE;
                    r_d.cyc   = 1'b0;
                    r_d.rdy   = 1'b1;
                    r_d.rdata = rd_aligned;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign wb_cyc_o  = r_q.cyc;
    assign wb_stb_o  = r_q.cyc;
    assign wb_we_o   = r_q.we && r_q.cyc;
    assign wb_adr_o  = r_q.adr;
    assign wb_dat_o  = r_q.dat;
    assign wb_sel_o  = r_q.sel;
    assign rsp_rdy   = r_q.rdy;
    assign rsp_rdata = r_q.rdata;

endmodule

// File: rtl/mem_wb_bridge_chk.sv
module mem_wb_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_cyc_o,
    input logic              wb_stb_o,
    input logic              wb_we_o,
    input logic [ADDR_W-1:0] wb_adr_o,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic [LANES-1:0]  wb_sel_o,
    input logic              wb_ack_i,
    input logic              rsp_rdy
);

    AST_STB_TRACKS_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb_o == wb_cyc_o); // R3

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_dat_o)
                                     && $stable(wb_sel_o) && $stable(wb_we_o))); // R4

    AST_CLOSE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o); // R5

    AST_RDY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_ack_i) |=> rsp_rdy); // R6

    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdy |=> !rsp_rdy); // R6

    AST_RDY_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdy |-> $past(wb_cyc_o && wb_ack_i)); // R6

    AST_SEL_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_cyc_o |-> (wb_sel_o != '0)); // R7

endmodule

bind mem_wb_bridge mem_wb_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wb_cyc_o (wb_cyc_o),
    .wb_stb_o (wb_stb_o),
    .wb_we_o  (wb_we_o),
    .wb_adr_o (wb_adr_o),
    .wb_dat_o (wb_dat_o),
    .wb_sel_o (wb_sel_o),
    .wb_ack_i (wb_ack_i),
    .rsp_rdy  (rsp_rdy)
);

// File: tb/mem_wb_bridge_tb.sv
module mem_wb_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [5:0]  req_size = '0;
    logic        req_wr = 1'b0;
    logic        req_rd = 1'b0;
    logic        rsp_rdy;
    logic [31:0] rsp_rdata;
    logic        wb_cyc_o, wb_stb_o, wb_we_o;
    logic [31:0] wb_adr_o, wb_dat_o;
    logic [3:0]  wb_sel_o;
    logic [31:0] wb_dat_i = '0;
    logic        wb_ack_i = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    mem_wb_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_size(req_size),
        .req_wr(req_wr), .req_rd(req_rd),
        .rsp_rdy(rsp_rdy), .rsp_rdata(rsp_rdata),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o),
        .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [5:0]  size;
        logic [31:0] wdata;
        logic [31:0] slv;
        logic [1:0]  waits;
        logic [3:0]  sel;
        logic [31:0] adr;
        logic [31:0] dat;
        logic [31:0] rd;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 32'h0000_0101, 6'd8,  32'hFFFF_FFA5, 32'h0, 2'd0, 4'b0010, 32'h0000_0100, 32'hA5A5_A5A5, 32'h0},
        '{1'b1, 32'h0000_0202, 6'd16, 32'h1234_BEEF, 32'h0, 2'd1, 4'b1100, 32'h0000_0200, 32'hBEEF_BEEF, 32'h0},
        '{1'b1, 32'h0000_0300, 6'd32, 32'h1234_5678, 32'h0, 2'd2, 4'b1111, 32'h0000_0300, 32'h1234_5678, 32'h0},
        '{1'b0, 32'h0000_0403, 6'd8,  32'h0,         32'hCAFE_F00D, 2'd3, 4'b1000, 32'h0000_0400, 32'h0, 32'h0000_00CA},
        '{1'b0, 32'h0000_0501, 6'd16, 32'h0,         32'h89AB_CDEF, 2'd0, 4'b0011, 32'h0000_0500, 32'h0, 32'h0000_CDEF},
        '{1'b0, 32'h0000_0600, 6'd32, 32'h0,         32'hDEAD_BEEF, 2'd1, 4'b1111, 32'h0000_0600, 32'h0, 32'hDEAD_BEEF},
        '{1'b1, 32'h0000_0703, 6'd24, 32'h0011_2233, 32'h0, 2'd0, 4'b1111, 32'h0000_0700, 32'h0011_2233, 32'h0},
        '{1'b0, 32'h0000_0802, 6'd16, 32'h0,         32'h5566_7788, 2'd2, 4'b1100, 32'h0000_0800, 32'h0, 32'h0000_5566}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present a request for one edge; returns at the negedge after acceptance
    task automatic launch(input logic wr, input logic rd, input logic [31:0] addr,
                          input logic [5:0] size, input logic [31:0] wdata);
        @(negedge clk);
        req_wr = wr; req_rd = rd; req_addr = addr; req_size = size; req_wdata = wdata;
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b0;
    endtask

    // slave answers after a number of wait cycles; returns at negedge after ack edge
    task automatic answer(input int waits, input logic [31:0] slv);
        for (int w = 0; w < waits; w++) begin
            chk("R4 cyc held while waiting", {31'b0, wb_cyc_o}, 32'd1);
            @(negedge clk);
        end
        wb_ack_i = 1'b1; wb_dat_i = slv;
        @(negedge clk);
        wb_ack_i = 1'b0; wb_dat_i = 32'h0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cyc in reset", {31'b0, wb_cyc_o}, 32'd0);
        chk("R1 rdy in reset", {31'b0, rsp_rdy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cyc/stb/we after reset", {29'b0, wb_cyc_o, wb_stb_o, wb_we_o}, 32'd0);
        chk("R1 rdy after reset", {31'b0, rsp_rdy}, 32'd0);

        for (int k = 0; k < 8; k++) begin
            launch(VEC[k].wr, !VEC[k].wr, VEC[k].addr, VEC[k].size, VEC[k].wdata);
            chk("R2 cyc/stb up", {30'b0, wb_cyc_o, wb_stb_o}, 32'd3);
            chk("R2 we", {31'b0, wb_we_o}, {31'b0, VEC[k].wr});
            chk("R7 sel", {28'b0, wb_sel_o}, {28'b0, VEC[k].sel});
            chk("R4 aligned adr", wb_adr_o, VEC[k].adr);
            if (VEC[k].wr) chk("R8 write data", wb_dat_o, VEC[k].dat);
            answer(int'(VEC[k].waits), VEC[k].slv);
            chk("R5 cyc/stb down", {30'b0, wb_cyc_o, wb_stb_o}, 32'd0);
            chk("R6 rdy pulse", {31'b0, rsp_rdy}, 32'd1);
            if (!VEC[k].wr) chk("R9 read data", rsp_rdata, VEC[k].rd);
            @(negedge clk);
            chk("R6 rdy one clock", {31'b0, rsp_rdy}, 32'd0);
        end

        // both strobes: write wins
        launch(1'b1, 1'b1, 32'h0000_0900, 6'd32, 32'hAABB_CCDD);
        chk("R2 write priority", {31'b0, wb_we_o}, 32'd1);
        answer(0, 32'h0);
        @(negedge clk);

        // strobes during an open cycle are dropped
        launch(1'b1, 1'b0, 32'h0000_0A00, 6'd32, 32'h1111_2222);
        req_wr = 1'b1; req_addr = 32'h0000_0B00; req_wdata = 32'h3333_4444;
        @(negedge clk);
        req_wr = 1'b0; req_rd = 1'b1;
        @(negedge clk);
        req_rd = 1'b0;
        chk("R10 adr unchanged while busy", wb_adr_o, 32'h0000_0A00);
        chk("R10 data unchanged while busy", wb_dat_o, 32'h1111_2222);
        answer(0, 32'h0);
        chk("R5 cycle closed", {31'b0, wb_cyc_o}, 32'd0);
        @(negedge clk);
        chk("R10 no queued cycle", {31'b0, wb_cyc_o}, 32'd0);
        @(negedge clk);
        chk("R10 still idle", {31'b0, wb_cyc_o}, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule